// File: doc/BRIEF.md
# Code-Protect Aware Program Checksum Unit

This unit computes the 16-bit checksum of a one-time-programmable program store. The caller pulses `start` while it presents the configuration word and the four identification words. It then streams program words as address/data pairs, in ascending address order. Gaps between words are allowed. The unit reads the protection code in the configuration word and, from it, decides how many low-order program words take part in the sum. It also decides whether a value packed from the identification words is added.

The implemented store size is set by the parameter `ADDR_W`: 9 gives 512 words, 10 gives 1024 and 11 gives 2048. Every sum is taken modulo 2^16. The unit raises `done` once the last word of the selected range has been added. The result then holds until the next `start`. Reading the store is left to the caller.

Top module: `cksum_acc`

## Requirements
- R1: The running sum is kept modulo 65536. Any carry out of bit 15 is dropped.
- R2: The configuration word is ANDed with 0x3F7F before it is added to the sum. Bit 7 and bits above 13 never contribute.
- R3: The identification value is {id0[3:0], id1[3:0], id2[3:0], id3[3:0]}, with id0 in the top nibble. For ids 0x12, 0x37, 0x4 and 0x26 it is 0x2746. It is added only when the selected range is smaller than the whole store.
- R4: The protection code is cfg_word[5:4]. Code 11 selects every implemented address (0 to 2^ADDR_W-1) and adds no identification value.
- R5: With 2048 words, code 01 sums addresses 0 to 511 and code 10 sums addresses 0 to 1023. With 1024 words, code 01 sums addresses 0 to 511.
- R6: Code 00, and any code that the store size does not define, selects no program words. `done` is high in the cycle after `start`, and the checksum is then the masked configuration word plus the identification value.
- R7: A word has no effect on the checksum if its address is at or above the selected range, or if it arrives while no computation is running (before any `start`, or after `done`).
- R8: `done` goes high in the cycle after the word at the highest selected address is accepted. It stays high until the next `start`.
- R9: With 2048 words, a blank store (every word 0x3FFF) and configuration 0x3FFF give the checksum 0x377F.
- R10: A `start` pulse in the middle of a stream drops the partial sum. It reloads the base value from the configuration presented with that pulse and clears `done`.
- R11: After reset, `checksum` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a new checksum |
| cfg_word | input | 14 | Configuration word, sampled with `start` |
| id0_word | input | 14 | Identification word 0, sampled with `start` |
| id1_word | input | 14 | Identification word 1, sampled with `start` |
| id2_word | input | 14 | Identification word 2, sampled with `start` |
| id3_word | input | 14 | Identification word 3, sampled with `start` |
| word_valid | input | 1 | Program word present this cycle |
| word_addr | input | ADDR_W | Address of the program word |
| word_data | input | 14 | Program word contents |
| checksum | output | 16 | Running and final checksum |
| done | output | 1 | Selected range fully summed |

## Verification
The bench builds two copies of the unit from one shared stimulus. One copy uses `ADDR_W` = 11 and the other uses `ADDR_W` = 10. With the 2048-word copy, all four protection codes can be reached, including the quarter-size range and the blank-store constant. The 1024-word copy covers a code that the smaller size does not define, where a `done` follows at once. It also covers address aliasing above its range, which must be ignored once its range is complete.

// File: rtl/cksum_pkg.sv
package cksum_pkg;

    localparam logic [13:0] CFG_MASK = 14'h3F7F;

    localparam logic [1:0] CP_NONE  = 2'b11;
    localparam logic [1:0] CP_LOW_A = 2'b01;
    localparam logic [1:0] CP_LOW_B = 2'b10;

    function automatic logic [15:0] pack_ids(
        input logic [13:0] i0,
        input logic [13:0] i1,
        input logic [13:0] i2,
        input logic [13:0] i3
    );
        return {i0[3:0], i1[3:0], i2[3:0], i3[3:0]};
    endfunction

endpackage

// File: rtl/cksum_cp_decode.sv
module cksum_cp_decode
    import cksum_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]      cp_code,
    output logic [ADDR_W:0] limit,
    output logic            include_id
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] FULL    = (ADDR_W + 1)'(DEPTH);
    localparam logic [ADDR_W:0] HALF    = (ADDR_W + 1)'(DEPTH / 2);
    localparam logic [ADDR_W:0] QUARTER = (ADDR_W + 1)'(DEPTH / 4);

    generate
        if (ADDR_W <= 9) begin : g_single
            always_comb begin
                limit = (cp_code == CP_NONE) ? FULL : '0;
            end
        end else if (ADDR_W == 10) begin : g_halves
            always_comb begin
                unique case (cp_code)
                    CP_NONE:  limit = FULL;
                    CP_LOW_A: limit = HALF;
                    default:  limit = '0;
                endcase
            end
        end else begin : g_quarters
            always_comb begin
                unique case (cp_code)
                    CP_NONE:  limit = FULL;
                    CP_LOW_B: limit = HALF;
                    CP_LOW_A: limit = QUARTER;
                    default:  limit = '0;
                endcase
            end
        end
    endgenerate

    assign include_id = (limit != FULL);

endmodule

// File: rtl/cksum_core.sv
module cksum_core #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       base,
    input  logic [ADDR_W:0]   limit,
    input  logic              word_valid,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [13:0]       word_data,
    output logic [15:0]       checksum,
    output logic              done
);
    typedef struct packed {
        logic            busy;
        logic            done;
        logic [ADDR_W:0] lim;
        logic [15:0]     acc;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic       in_range_d;
    logic       is_last_d;

    always_comb begin
        st_d       = st_q;
        in_range_d = word_valid && st_q.busy && ({1'b0, word_addr} < st_q.lim);
        is_last_d  = ({1'b0, word_addr} == (st_q.lim - 1'b1));
        if (start) begin
            st_d.acc  = base;
            st_d.lim  = limit;
            st_d.busy = (limit != '0);
            st_d.done = (limit == '0);
        end else if (in_range_d) begin
            st_d.acc = st_q.acc + {2'b00, word_data};
            if (is_last_d) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign checksum = st_q.acc;
    assign done     = st_q.done;

    a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && in_range_d && is_last_d) |=> done);

    a_r7_hold_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !in_range_d) |=> $stable(checksum));

    a_r6_empty_range: assert property (@(posedge clk) disable iff (!rst_n)
        (start && limit == '0) |=> (done && checksum == $past(base)));

    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && limit != '0) |=> (!done && checksum == $past(base)));

endmodule

// File: rtl/cksum_acc.sv
module cksum_acc
    import cksum_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [13:0]       cfg_word,
    input  logic [13:0]       id0_word,
    input  logic [13:0]       id1_word,
    input  logic [13:0]       id2_word,
    input  logic [13:0]       id3_word,
    input  logic              word_valid,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [13:0]       word_data,
    output logic [15:0]       checksum,
    output logic              done
);
    logic [ADDR_W:0] limit_w;
    logic            include_id_w;
    logic [15:0]     id_val_w;
    logic [15:0]     base_w;

    cksum_cp_decode #(.ADDR_W(ADDR_W)) decode_i (
        .cp_code    (cfg_word[5:4]),
        .limit      (limit_w),
        .include_id (include_id_w)
    );

    assign id_val_w = pack_ids(id0_word, id1_word, id2_word, id3_word);
    assign base_w   = {2'b00, cfg_word & CFG_MASK} + (include_id_w ? id_val_w : 16'h0000);

    cksum_core #(.ADDR_W(ADDR_W)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .base       (base_w),
        .limit      (limit_w),
        .word_valid (word_valid),
        .word_addr  (word_addr),
        .word_data  (word_data),
        .checksum   (checksum),
        .done       (done)
    );

endmodule

// File: tb/cksum_acc_tb_top.sv
module cksum_ref_model #(
    parameter int SIZE = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [13:0] cfg,
    input  logic [13:0] i0,
    input  logic [13:0] i1,
    input  logic [13:0] i2,
    input  logic [13:0] i3,
    input  logic        valid,
    input  int          addr,
    input  logic [13:0] data,
    output int          m_sum,
    output bit          m_done
);
    int m_lim;
    bit m_busy;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sum = 0; m_done = 0; m_busy = 0; m_lim = 0;
        end else if (start) begin
            int cp;
            cp = (int'(cfg) >> 4) & 3;
            if (cp == 3) m_lim = SIZE;
            else if (SIZE == 2048 && cp == 1) m_lim = 512;
            else if (SIZE == 2048 && cp == 2) m_lim = 1024;
            else if (SIZE == 1024 && cp == 1) m_lim = 512;
            else m_lim = 0;
            m_sum = int'(cfg) & 'h3F7F;
            if (m_lim < SIZE)
                m_sum = m_sum + ((int'(i0) & 15) * 4096) + ((int'(i1) & 15) * 256)
                              + ((int'(i2) & 15) * 16) + (int'(i3) & 15);
            m_sum  = m_sum % 65536;
            m_busy = (m_lim > 0);
            m_done = (m_lim == 0);
        end else if (valid && m_busy && addr < m_lim) begin
            m_sum = (m_sum + int'(data)) % 65536;
            if (addr == m_lim - 1) begin
                m_busy = 0;
                m_done = 1;
            end
        end
    end
endmodule

module cksum_acc_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic [13:0] cfg = 0, id0 = 0, id1 = 0, id2 = 0, id3 = 0;
    logic        w_valid = 0;
    logic [10:0] w_addr = 0;
    logic [13:0] w_data = 0;
    logic [15:0] sum_2k, sum_1k;
    logic        done_2k, done_1k;
    int          m_sum_2k, m_sum_1k;
    bit          m_done_2k, m_done_1k;
    int          errors = 0;
    int          checks = 0;
    bit          cmp_en = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cksum_acc #(.ADDR_W(11)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg),
        .id0_word(id0), .id1_word(id1), .id2_word(id2), .id3_word(id3),
        .word_valid(w_valid), .word_addr(w_addr), .word_data(w_data),
        .checksum(sum_2k), .done(done_2k));

    cksum_acc #(.ADDR_W(10)) dut_1k_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg),
        .id0_word(id0), .id1_word(id1), .id2_word(id2), .id3_word(id3),
        .word_valid(w_valid), .word_addr(w_addr[9:0]), .word_data(w_data),
        .checksum(sum_1k), .done(done_1k));

    cksum_ref_model #(.SIZE(2048)) model_2k_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg), .i0(id0), .i1(id1),
        .i2(id2), .i3(id3), .valid(w_valid), .addr(int'(w_addr)), .data(w_data),
        .m_sum(m_sum_2k), .m_done(m_done_2k));

    cksum_ref_model #(.SIZE(1024)) model_1k_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg), .i0(id0), .i1(id1),
        .i2(id2), .i3(id3), .valid(w_valid), .addr(int'(w_addr[9:0])), .data(w_data),
        .m_sum(m_sum_1k), .m_done(m_done_1k));

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the behavioural model (R1, R7, R8).
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk(int'(sum_2k) == m_sum_2k, "R1 cycle sum 2K", int'(sum_2k), m_sum_2k);
            chk(done_2k == m_done_2k, "R8 cycle done 2K", int'(done_2k), int'(m_done_2k));
            chk(int'(sum_1k) == m_sum_1k, "R7 cycle sum 1K", int'(sum_1k), m_sum_1k);
            chk(done_1k == m_done_1k, "R8 cycle done 1K", int'(done_1k), int'(m_done_1k));
        end
    end

    function automatic int word_at(int a, bit blank);
        return blank ? 'h3FFF : ((a * 613 + 77) & 'h3FFF);
    endfunction

    function automatic int expected(int size, bit blank);
        int cp, lim, s;
        cp = (int'(cfg) >> 4) & 3;
        if (cp == 3) lim = size;
        else if (size == 2048 && cp == 1) lim = 512;
        else if (size == 2048 && cp == 2) lim = 1024;
        else if (size == 1024 && cp == 1) lim = 512;
        else lim = 0;
        s = int'(cfg) & 'h3F7F;
        for (int a = 0; a < lim; a++) s += word_at(a, blank);
        if (lim < size)
            s += ((int'(id0) & 15) << 12) | ((int'(id1) & 15) << 8)
               | ((int'(id2) & 15) << 4) | (int'(id3) & 15);
        return s & 'hFFFF;
    endfunction

    task automatic pulse_start(input logic [13:0] c);
        @(negedge clk);
        cfg   = c;
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic stream(input int n, input bit blank);
        for (int a = 0; a < n; a++) begin
            if (a % 7 == 3) begin
                w_valid = 0;
                w_addr  = 11'(a + 5);
                w_data  = 14'h2AAA;
                @(negedge clk);
            end
            w_valid = 1;
            w_addr  = 11'(a);
            w_data  = 14'(word_at(a, blank));
            @(negedge clk);
        end
        w_valid = 0;
    endtask

    task automatic run_case(input logic [13:0] c, input bit blank, input string tag);
        int e2, e1;
        pulse_start(c);
        stream(2048, blank);
        repeat (2) @(negedge clk);
        e2 = expected(2048, blank);
        e1 = expected(1024, blank);
        chk(int'(sum_2k) == e2, {tag, " final sum 2K"}, int'(sum_2k), e2);
        chk(done_2k == 1'b1, {tag, " done 2K"}, int'(done_2k), 1);
        chk(int'(sum_1k) == e1, {tag, " final sum 1K"}, int'(sum_1k), e1);
        chk(done_1k == 1'b1, {tag, " done 1K"}, int'(done_1k), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(sum_2k == 16'h0 && done_2k == 1'b0, "R11 reset 2K", int'(sum_2k), 0);
        chk(sum_1k == 16'h0 && done_1k == 1'b0, "R11 reset 1K", int'(sum_1k), 0);
        cmp_en = 1;

        // R9 / R4 / R2: blank store, no protection
        run_case(14'h3FFF, 1'b1, "R9 blank");
        chk(sum_2k == 16'h377F, "R9 blank constant 2K", int'(sum_2k), 'h377F);
        chk(sum_1k == 16'h3B7F, "R4 blank constant 1K", int'(sum_1k), 'h3B7F);

        id0 = 14'h0012; id1 = 14'h0037; id2 = 14'h0004; id3 = 14'h0026;

        // R4 patterned, bit 7 set and masked (R2)
        run_case(14'h2AB5 | 14'h0030, 1'b0, "R4 off");

        // R5: code 10 -> 2K half, 1K undefined -> empty range (R6)
        pulse_start(14'h1FA1);
        chk(done_1k == 1'b1, "R6 undefined code done next cycle 1K", int'(done_1k), 1);
        chk(done_2k == 1'b0, "R5 busy 2K", int'(done_2k), 0);
        stream(2048, 1'b0);
        repeat (2) @(negedge clk);
        chk(int'(sum_2k) == expected(2048, 0), "R5 code 10 sum 2K", int'(sum_2k), expected(2048, 0));
        chk(int'(sum_1k) == ((int'(14'h1FA1) & 'h3F7F) + 'h2746) % 65536,
            "R6 undefined code sum 1K", int'(sum_1k), ((int'(14'h1FA1) & 'h3F7F) + 'h2746) % 65536);

        // R5: code 01 on both sizes
        run_case(14'h05D9, 1'b0, "R5 code 01");

        // R3 / R6: code 00, ID example value 0x2746
        pulse_start(14'h0080);
        chk(sum_2k == 16'h2746, "R3 id packing 2K", int'(sum_2k), 'h2746);
        chk(done_2k == 1'b1, "R6 empty range done 2K", int'(done_2k), 1);

        // R7: word after done has no effect
        @(negedge clk);
        w_valid = 1; w_addr = 11'd0; w_data = 14'h1234;
        @(negedge clk);
        w_valid = 0;
        @(negedge clk);
        chk(sum_2k == 16'h2746, "R7 word after done 2K", int'(sum_2k), 'h2746);

        // R10: restart mid-stream
        pulse_start(14'h3FFF);
        stream(100, 1'b0);
        chk(done_2k == 1'b0, "R10 partial not done", int'(done_2k), 0);
        run_case(14'h3E5F, 1'b0, "R10 restart");

        // R1: large full-range sum wraps
        id0 = 14'h3FFF; id1 = 14'h3FF0; id2 = 14'h000F; id3 = 14'h1235;
        run_case(14'h3FFF, 1'b0, "R1 wrap");

        cmp_en = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule